// File: doc/BRIEF.md
# Cache-Maintenance Permission Register Bank

This block holds the permission setting for every numbered cache-maintenance and prefetch operation. Each operation has a 2-bit permission field, and the fields are packed 32 to a 64-bit control register. The control registers are read and written through a simple register port. A separate lookup port lets the instruction decoder fetch the field for one operation number within the same cycle.

The field values mean: 00 disables the operation, 01 sends it to a machine-mode trap, and 11 allows it at every privilege level, user level included. The value 10 is reserved. Writes follow a write-anything, read-legal rule:

- Operations that the implementation does not build have fields fixed at 00. Software can write anything to them, and reading them back shows which operations exist.
- Operations declared equivalent share a single storage cell, so a write through any one of them shows up at all of them.

Two elaboration parameters configure this. An implemented-operation mask says which operations exist. An equivalence link mask joins each operation to the one below it, so each group is a run of consecutive operation numbers.

Top module: `cmo_perm_bank`

## Requirements
- R1: The field for operation J sits in register J/32 at bits 2*(J mod 32)+1 down to 2*(J mod 32). The lookup port returns that same field for index J.
- R2: A write of 00 (disabled), 01 (machine trap) or 11 (any mode) to an implemented field is stored and read back unchanged.
- R3: A write of the reserved value 10 to an implemented field stores 00. No port ever returns 10 in any field.
- R4: A field whose bit in IMPL_MASK is 0 reads 00 through both ports, whatever is written to it.
- R5: Operations J-1 and J with LINK_MASK[J]=1 belong to one group. A write through any implemented member of a group is seen at every implemented member. Bit 0 of LINK_MASK has no effect.
- R6: When one write covers several implemented members of the same group, the lowest-numbered of those members in the written register sets the group value.
- R7: Reset (synchronous, active high) clears every field to 00 and clears csr_rdata to 0.
- R8: At each clock edge csr_rdata takes the contents of register csr_sel as they were before that edge. For a csr_sel of N_OPS/32 or higher, csr_rdata is 0 and writes have no effect.
- R9: lookup_perm is combinational. It reflects lookup_idx and the stored fields in the same cycle.
- R10: With csr_we low, no field changes, whatever csr_wdata and csr_sel are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | SEL_W | Register number for read and write |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_wdata | input | 64 | Write data, 32 packed 2-bit fields |
| csr_rdata | output | 64 | Registered contents of the selected register |
| lookup_idx | input | log2(N_OPS) | Operation number to look up |
| lookup_perm | output | 2 | Permission field of lookup_idx |

## Verification
Each register is written with uniform patterns: all ones, the all-01 pattern and the all-reserved pattern. These show the stored legal values apart from the reserved value being turned into 00. A sequence of pseudo-random words then places different values on adjacent fields, which would expose a misplaced bit slice or a group that takes its value from the wrong member. Targeted words put conflicting values on members of a group that spans two registers, to check which member wins and that the shared cell is seen across the register boundary. Writes to an out-of-range register, cycles with the strobe low, and a reset in the middle of a run show that none of these leak into the stored state. Every write is followed by a sweep over all registers and all 64 operation numbers.

// File: rtl/cmo_perm_pkg.sv
package cmo_perm_pkg;

  typedef enum logic [1:0] {
    PERM_OFF  = 2'b00,
    PERM_TRAP = 2'b01,
    PERM_RSVD = 2'b10,
    PERM_ANY  = 2'b11
  } perm_e;

  localparam int unsigned REG_W = 64;
  localparam int unsigned FLD_W = 2;
  localparam int unsigned FPR   = REG_W / FLD_W;

  // Map the reserved code onto the disabled code; legal codes pass through.
  function automatic logic [1:0] legalize(input logic [1:0] v);
    return (v == PERM_RSVD) ? PERM_OFF : v;
  endfunction

endpackage

// File: rtl/cmo_perm_store.sv
module cmo_perm_store
  import cmo_perm_pkg::*;
#(
  parameter int unsigned N_OPS = 64,
  parameter int unsigned SEL_W = 3,
  parameter logic [N_OPS-1:0] IMPL_MASK = '1,
  parameter logic [N_OPS-1:0] LINK_MASK = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [REG_W-1:0]       wr_data,
  output logic [N_OPS*FLD_W-1:0] fields
);

  localparam int unsigned IDX_W = (N_OPS > 1) ? $clog2(N_OPS) : 1;

  // Representative (lowest member) of each operation's group.
  function automatic logic [N_OPS*IDX_W-1:0] build_reps();
    logic [N_OPS*IDX_W-1:0] v;
    int r;
    v = '0;
    for (int j = 0; j < N_OPS; j++) begin
      r = j;
      if (j > 0 && LINK_MASK[j]) r = int'(v[(j-1)*IDX_W +: IDX_W]);
      v[j*IDX_W +: IDX_W] = IDX_W'(r);
    end
    return v;
  endfunction

  localparam logic [N_OPS*IDX_W-1:0] REP_V = build_reps();

  // True when some implemented operation belongs to the group led by g.
  function automatic bit group_live(input int g);
    bit live;
    live = 1'b0;
    for (int k = 0; k < N_OPS; k++)
      if (int'(REP_V[k*IDX_W +: IDX_W]) == g && IMPL_MASK[k]) live = 1'b1;
    return live;
  endfunction

  logic [1:0] slot [N_OPS];

  for (genvar j = 0; j < N_OPS; j++) begin : g_op
    localparam int REP = int'(REP_V[j*IDX_W +: IDX_W]);

    if (REP == j && group_live(j)) begin : g_cell
      logic       hit;
      logic [1:0] nxt;
      logic [1:0] cell_q;

      // Descending scan: the lowest member in the written register wins.
      always_comb begin
        hit = 1'b0;
        nxt = PERM_OFF;
        for (int k = N_OPS - 1; k >= j; k--) begin
          if (int'(REP_V[k*IDX_W +: IDX_W]) == j && IMPL_MASK[k] &&
              wr_sel == SEL_W'(k / FPR)) begin
            hit = 1'b1;
            nxt = legalize(wr_data[(k % FPR)*FLD_W +: FLD_W]);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst)               cell_q <= PERM_OFF;
        else if (wr_en && hit) cell_q <= nxt;
      end

      assign slot[j] = cell_q;
    end else begin : g_nocell
      assign slot[j] = PERM_OFF;
    end

    assign fields[j*FLD_W +: FLD_W] = IMPL_MASK[j] ? slot[REP] : PERM_OFF;
  end

endmodule

// File: rtl/cmo_perm_rdport.sv
module cmo_perm_rdport
  import cmo_perm_pkg::*;
#(
  parameter int unsigned N_OPS = 64,
  parameter int unsigned SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SEL_W-1:0]       rd_sel,
  input  logic [N_OPS*FLD_W-1:0] fields,
  output logic [REG_W-1:0]       rd_data
);

  localparam int unsigned N_REGS = N_OPS / FPR;

  logic [REG_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int r = 0; r < N_REGS; r++)
      if (rd_sel == SEL_W'(r)) rd_d = fields[r*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

endmodule

// File: rtl/cmo_perm_lookup.sv
module cmo_perm_lookup
  import cmo_perm_pkg::*;
#(
  parameter int unsigned N_OPS = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0]       idx,
  input  logic [N_OPS*FLD_W-1:0] fields,
  output logic [FLD_W-1:0]       perm
);

  always_comb begin
    perm = PERM_OFF;
    for (int j = 0; j < N_OPS; j++)
      if (idx == IDX_W'(j)) perm = fields[j*FLD_W +: FLD_W];
  end

endmodule

// File: rtl/cmo_perm_bank.sv
module cmo_perm_bank
  import cmo_perm_pkg::*;
#(
  parameter int unsigned N_OPS = 64,
  parameter int unsigned SEL_W = 3,
  parameter logic [N_OPS-1:0] IMPL_MASK = 64'hFFFF_00FF_FFFF_F0FF,
  parameter logic [N_OPS-1:0] LINK_MASK = 64'h0000_0003_8006_0108,
  localparam int unsigned IDX_W = (N_OPS > 1) ? $clog2(N_OPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] csr_sel,
  input  logic             csr_we,
  input  logic [63:0]      csr_wdata,
  output logic [63:0]      csr_rdata,
  input  logic [IDX_W-1:0] lookup_idx,
  output logic [1:0]       lookup_perm
);

  logic [N_OPS*FLD_W-1:0] fields;

  cmo_perm_store #(
    .N_OPS(N_OPS), .SEL_W(SEL_W), .IMPL_MASK(IMPL_MASK), .LINK_MASK(LINK_MASK)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(csr_we), .wr_sel(csr_sel),
    .wr_data(csr_wdata), .fields(fields)
  );

  cmo_perm_rdport #(.N_OPS(N_OPS), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_sel(csr_sel), .fields(fields), .rd_data(csr_rdata)
  );

  cmo_perm_lookup #(.N_OPS(N_OPS), .IDX_W(IDX_W)) u_lk (
    .idx(lookup_idx), .fields(fields), .perm(lookup_perm)
  );

endmodule

// File: rtl/cmo_perm_bank_chk.sv
module cmo_perm_bank_chk #(
  parameter int unsigned N_OPS = 64,
  parameter int unsigned SEL_W = 3,
  parameter logic [N_OPS-1:0] IMPL_MASK = '1,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] csr_sel,
  input logic             csr_we,
  input logic [63:0]      csr_rdata,
  input logic [IDX_W-1:0] lookup_idx,
  input logic [1:0]       lookup_perm
);

  localparam int unsigned N_REGS = N_OPS / 32;

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R7: the cycle after a reset edge shows an empty read register
  always @(negedge clk)
    if (rst_seen_q)
      assert_rst_clear_R7: assert (csr_rdata == 64'd0);

  // R3: lookup never yields the reserved code
  assert_lookup_legal_R3: assert property (@(posedge clk) disable iff (rst)
    lookup_perm != 2'b10);

  for (genvar f = 0; f < 32; f++) begin : g_fld
    // R3: no field of the read register carries the reserved code
    assert_rd_legal_R3: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[2*f +: 2] != 2'b10);
  end

  // R4: unimplemented operations look up as disabled
  assert_unimpl_off_R4: assert property (@(posedge clk) disable iff (rst)
    !IMPL_MASK[lookup_idx] |-> lookup_perm == 2'b00);

  // R8: an out-of-range select reads zero on the next cycle
  assert_oob_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(csr_sel) >= SEL_W'(N_REGS)) |-> csr_rdata == 64'd0);

  // R10: no write strobe and a steady index keep the looked-up field steady
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(csr_we) && $stable(lookup_idx)) |-> $stable(lookup_perm));

endmodule

bind cmo_perm_bank cmo_perm_bank_chk #(
  .N_OPS(N_OPS), .SEL_W(SEL_W), .IMPL_MASK(IMPL_MASK), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
  .csr_rdata(csr_rdata), .lookup_idx(lookup_idx), .lookup_perm(lookup_perm)
);

// File: tb/cmo_perm_bank_bench.sv
module cmo_perm_bank_bench;

  localparam int NOPS = 64;
  localparam int NREG = 2;
  localparam logic [63:0] IMPL = 64'hFFFF_00FF_FFFF_F0FF;
  localparam logic [63:0] LINK = 64'h0000_0003_8006_0108;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  csr_sel = '0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic [5:0]  lookup_idx = '0;
  logic [1:0]  lookup_perm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int          rep [NOPS];
  logic [1:0]  grp [NOPS];

  always #4 clk = ~clk;

  cmo_perm_bank u_cmo_perm_bank (
    .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .lookup_idx(lookup_idx), .lookup_perm(lookup_perm)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_field(input int j);
    return IMPL[j] ? grp[rep[j]] : 2'b00;
  endfunction

  function automatic logic [63:0] exp_reg(input int r);
    logic [63:0] v = '0;
    for (int f = 0; f < 32; f++) v[2*f +: 2] = exp_field(r*32 + f);
    return v;
  endfunction

  function automatic void model_reset();
    for (int j = 0; j < NOPS; j++) grp[j] = 2'b00;
  endfunction

  function automatic void model_write(input int sel, input logic [63:0] d);
    for (int g = 0; g < NOPS; g++) begin
      if (rep[g] == g) begin
        for (int k = NOPS - 1; k >= g; k--) begin
          if (rep[k] == g && IMPL[k] && (k / 32) == sel) begin
            grp[g] = (d[2*(k%32) +: 2] == 2'b10) ? 2'b00 : d[2*(k%32) +: 2];
          end
        end
      end
    end
  endfunction

  task automatic do_write(input int sel, input logic [63:0] d);
    @(negedge clk);
    csr_sel = 3'(sel); csr_wdata = d; csr_we = 1'b1;
    @(posedge clk);
    model_write(sel, d);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic read_reg(input int sel, input string tag, input logic [63:0] exp);
    @(negedge clk);
    csr_sel = 3'(sel);
    @(negedge clk);
    check(tag, csr_rdata, exp);
  endtask

  task automatic look(input int j, input string tag, input logic [1:0] exp);
    @(negedge clk);
    lookup_idx = 6'(j);
    #1;
    check(tag, {62'd0, lookup_perm}, {62'd0, exp});
  endtask

  task automatic sweep();
    for (int r = 0; r < NREG; r++) read_reg(r, "R1 R8 register read", exp_reg(r));
    for (int j = 0; j < NOPS; j++) begin
      if (!IMPL[j])         look(j, "R4 R9 unimplemented lookup", exp_field(j));
      else if (rep[j] != j) look(j, "R5 R9 group member lookup", exp_field(j));
      else                  look(j, "R1 R9 lookup", exp_field(j));
    end
  endtask

  initial begin
    logic [63:0] lfsr;
    for (int j = 0; j < NOPS; j++) rep[j] = (j > 0 && LINK[j]) ? rep[j-1] : j;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R7: reset state
    read_reg(0, "R7 reset reg0", 64'd0);
    read_reg(1, "R7 reset reg1", 64'd0);
    sweep();

    // R2: all-ones and all-01 patterns
    do_write(0, '1); do_write(1, '1);
    sweep();
    look(9, "R4 unimplemented after ones", 2'b00);
    look(8, "R4 unimplemented group member", 2'b00);
    look(7, "R2 any-mode stored", 2'b11);
    do_write(0, {32{2'b01}}); do_write(1, {32{2'b01}});
    look(5, "R2 trap stored", 2'b01);
    sweep();

    // R3: reserved pattern becomes disabled
    do_write(0, {32{2'b10}}); do_write(1, {32{2'b10}});
    look(20, "R3 reserved to off", 2'b00);
    sweep();

    // R1 R6: pseudo-random words
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 10; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = lfsr ^ (lfsr << 13) ^ (lfsr >> 7);
      do_write(n % NREG, lfsr);
      sweep();
    end

    // R6: conflict inside group 30..33, lowest member in reg0 (30) wins
    do_write(0, (64'h1 << 60) | (64'h3 << 62));
    look(33, "R6 conflict winner seen in reg1", 2'b01);
    look(31, "R6 conflict loser overridden", 2'b01);
    // R5: write through member 32 in reg1 is visible at 30
    do_write(1, 64'h3);
    look(30, "R5 cross-register group share", 2'b11);
    sweep();

    // R10: strobe low, data and select moving
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      csr_we = 1'b0; csr_sel = 3'(n % NREG); csr_wdata = ~csr_wdata ^ 64'(n);
    end
    sweep();

    // R8: out-of-range register
    do_write(5, '1);
    read_reg(5, "R8 out-of-range reads zero", 64'd0);
    sweep();

    // R7: reset in mid-run
    do_write(0, '1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    check("R7 rdata after mid-run reset", csr_rdata, 64'd0);
    sweep();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule